// File: doc/BRIEF.md
# Parallel port configuration register unit

This block models the configuration side of the parallel port function inside a multi-function I/O controller. It sits on a byte-wide I/O bus and occupies two addresses: an index port and a data port at the next address up. The configuration registers are locked at power-up. To unlock them, software writes a device key byte to the index port twice in a row. It then writes a register number to the index port and reads or writes that register through the data port. Writing an exit code to the index port locks the registers again.

The register contents are decoded straight into outputs that the parallel port datapath consumes: the I/O base address of the port, the choice between plain SPP operation and an extended mode, the 2-bit extended mode and the EPP protocol version. One parameter selects between two device variants, which differ in key, identification byte and whether the mode fields can be written. A second parameter moves the index port to an alternate location.

Top module: `sio_ppcfg`

## Requirements
- R1: After reset the unit is locked. `port_base` is 0x378 and `epp_v17` is 0. Variant A shows `spp_sel`=1 and `ext_mode`=0; variant B shows `spp_sel`=0 and `ext_mode`=3.
- R2: Configuration mode is entered only by two consecutive writes of the key byte to the index port. The key is 0x55 for variant A and 0x44 for variant B. Idle cycles between the two writes are allowed.
- R3: A key write followed by any other write, to any address, cancels the sequence. A single key write after that does not unlock the unit.
- R4: While unlocked, writing 0xAA to the index port locks the unit. Any other byte written there becomes the register index.
- R5: While locked, reads of the data port return 0xFF and writes to the data port change no register.
- R6: While unlocked, index 0x0D reads back the device ID: 0x65 for variant A and 0x66 for variant B.
- R7: Bits 1:0 of register 0x01 select `port_base`: 0 gives 0x000 (disabled), 1 gives 0x3BC, 2 gives 0x378 and 3 gives 0x278. The register reads back as written.
- R8: Bit 3 of register 0x01 drives `spp_sel`. A 1 means plain SPP; a 0 means the extended mode in register 0x04 applies.
- R9: Bits 1:0 of register 0x04 drive `ext_mode`: 0 = SPP, 1 = EPP+SPP, 2 = ECP, 3 = ECP+EPP.
- R10: Bit 6 of register 0x04 drives `epp_v17`. A 0 selects the IEEE 1284 (1.9) EPP protocol and a 1 selects the 1.7 protocol.
- R11: Variant B is hardwired to an extended mode. Register 0x01 bit 3 always reads 0 and register 0x04 bits 1:0 always read 3, whatever is written; the other bits of both registers stay writable.
- R12: The index port is at 0x3F0, or at 0x370 when ALT_INDEX=1, and the data port is the next address. Writes to any other address have no effect other than R3.
- R13: While unlocked, data port reads at any index other than 0x01, 0x04 and 0x0D return 0x00. Reads at any address other than the data port return 0xFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | ADDR_W | I/O address |
| io_wr | input | 1 | Write strobe, one write per cycle |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for the current address (combinational) |
| port_base | output | ADDR_W | Selected parallel port base address, 0 when disabled |
| spp_sel | output | 1 | 1 = plain SPP, 0 = extended mode |
| ext_mode | output | 2 | Extended mode field |
| epp_v17 | output | 1 | 1 = EPP 1.7, 0 = EPP 1.9 |

## Verification
The bench targets the unlock sequence. It writes the key and then a write to an unrelated address before the second key; a design that does not cancel would unlock and read back real registers instead of 0xFF. It also writes the key of one variant at the other variant's index address; a design that decodes the wrong address or key would open the wrong unit. Writes made while locked are followed by an unlock and a readback, so that a design leaking locked writes into the registers shows the corrupted value. On the hardwired variant, writes that try to clear the extended mode must leave `spp_sel` low and `ext_mode` at 3, while the EPP version bit must still follow the write.

// File: rtl/sio_ppcfg.sv
module sio_ppcfg #(
  parameter int VARIANT   = 0,
  parameter bit ALT_INDEX = 1'b0,
  parameter int ADDR_W    = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_wr,
  input  logic [7:0]        io_wdata,
  output logic [7:0]        io_rdata,
  output logic [ADDR_W-1:0] port_base,
  output logic              spp_sel,
  output logic [1:0]        ext_mode,
  output logic              epp_v17
);
  localparam logic [ADDR_W-1:0] IDX_ADDR = ALT_INDEX ? ADDR_W'(16'h370) : ADDR_W'(16'h3F0);
  localparam logic [ADDR_W-1:0] DAT_ADDR = IDX_ADDR + ADDR_W'(1);
  localparam bit        FIXED   = (VARIANT != 0);
  localparam logic [7:0] KEY    = FIXED ? 8'h44 : 8'h55;
  localparam logic [7:0] DEV_ID = FIXED ? 8'h66 : 8'h65;
  localparam logic [7:0] EXIT   = 8'hAA;
  localparam logic [7:0] CR1_RST = FIXED ? 8'h02 : 8'h0A;
  localparam logic [7:0] CR4_RST = FIXED ? 8'h03 : 8'h00;

  logic       unlocked, armed;
  logic [7:0] idx, cr1, cr4;

  wire idx_wr = io_wr && (io_addr == IDX_ADDR);
  wire dat_wr = io_wr && (io_addr == DAT_ADDR);
  wire is_key = (io_wdata == KEY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
      armed    <= 1'b0;
      idx      <= 8'h00;
      cr1      <= CR1_RST;
      cr4      <= CR4_RST;
    end else begin
      if (io_wr) armed <= idx_wr && !unlocked && is_key && !armed;
      if (idx_wr) begin
        if (!unlocked) begin
          if (is_key && armed) unlocked <= 1'b1;
        end else if (io_wdata == EXIT) begin
          unlocked <= 1'b0;
        end else begin
          idx <= io_wdata;
        end
      end
      if (dat_wr && unlocked) begin
        if (idx == 8'h01) cr1 <= FIXED ? {io_wdata[7:4], 1'b0, io_wdata[2:0]} : io_wdata;
        if (idx == 8'h04) cr4 <= FIXED ? {io_wdata[7:2], 2'b11} : io_wdata;
      end
    end
  end

  always_comb begin
    io_rdata = 8'hFF;
    if (io_addr == DAT_ADDR && unlocked) begin
      case (idx)
        8'h01:   io_rdata = cr1;
        8'h04:   io_rdata = cr4;
        8'h0D:   io_rdata = DEV_ID;
        default: io_rdata = 8'h00;
      endcase
    end
  end

  always_comb begin
    case (cr1[1:0])
      2'd0:    port_base = '0;
      2'd1:    port_base = ADDR_W'(16'h3BC);
      2'd2:    port_base = ADDR_W'(16'h378);
      default: port_base = ADDR_W'(16'h278);
    endcase
  end

  assign spp_sel  = cr1[3];
  assign ext_mode = cr4[1:0];
  assign epp_v17  = cr4[6];

  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unlocked) |-> $past(idx_wr && is_key && armed));
  p_cancel_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && io_wr && !(idx_wr && is_key)) |=> (!unlocked && !armed));
  p_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unlocked && idx_wr && io_wdata == EXIT) |=> !unlocked);
  p_locked_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!unlocked && io_addr == DAT_ADDR) |-> io_rdata == 8'hFF);
  p_locked_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked |=> ($stable(cr1) && $stable(cr4)));
  p_fixed_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (FIXED && dat_wr) |=> ($stable(ext_mode) && $stable(spp_sel)));
endmodule

// File: tb/sio_ppcfg_bench.sv
module sio_ppcfg_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = 16'h0000;
  logic        io_wr = 1'b0;
  logic [7:0]  io_wdata = 8'h00;
  logic [7:0]  rd_a, rd_b;
  logic [15:0] base_a, base_b;
  logic        spp_a, spp_b, epp_a, epp_b;
  logic [1:0]  ext_a, ext_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sio_ppcfg u_sio_ppcfg (.clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(rd_a), .port_base(base_a), .spp_sel(spp_a),
    .ext_mode(ext_a), .epp_v17(epp_a));
  sio_ppcfg #(.VARIANT(1), .ALT_INDEX(1'b1)) u_sio_ppcfg_b (.clk(clk), .rst_n(rst_n),
    .io_addr(io_addr), .io_wr(io_wr), .io_wdata(io_wdata), .io_rdata(rd_b),
    .port_base(base_b), .spp_sel(spp_b), .ext_mode(ext_b), .epp_v17(epp_b));

  int m_unl[2], m_arm[2], m_idx[2], m_cr1[2], m_cr4[2];
  int KEYV[2] = '{32'h55, 32'h44};
  int IDV[2]  = '{32'h65, 32'h66};
  int IXA[2]  = '{32'h3F0, 32'h370};

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int e_base(int k);
    case (m_cr1[k] % 4)
      0: return 0;
      1: return 'h3BC;
      2: return 'h378;
      default: return 'h278;
    endcase
  endfunction

  function automatic int e_rd(int k);
    if (io_addr != IXA[k] + 1 || m_unl[k] == 0) return 'hFF;
    if (m_idx[k] == 1) return m_cr1[k];
    if (m_idx[k] == 4) return m_cr4[k];
    if (m_idx[k] == 'h0D) return IDV[k];
    return 0;
  endfunction

  always @(posedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst_n) begin
        m_unl[k] = 0; m_arm[k] = 0; m_idx[k] = 0;
        m_cr1[k] = (k == 0) ? 'h0A : 'h02;
        m_cr4[k] = (k == 0) ? 'h00 : 'h03;
      end else if (io_wr) begin
        if (io_addr == IXA[k] && m_unl[k] == 0) begin
          if (io_wdata == KEYV[k]) begin
            if (m_arm[k] != 0) begin m_unl[k] = 1; m_arm[k] = 0; end
            else m_arm[k] = 1;
          end else m_arm[k] = 0;
        end else if (io_addr == IXA[k]) begin
          if (io_wdata == 8'hAA) m_unl[k] = 0; else m_idx[k] = io_wdata;
          m_arm[k] = 0;
        end else begin
          m_arm[k] = 0;
          if (io_addr == IXA[k] + 1 && m_unl[k] != 0) begin
            if (m_idx[k] == 1) m_cr1[k] = (k == 1) ? (io_wdata & 'hF7) : io_wdata;
            if (m_idx[k] == 4) m_cr4[k] = (k == 1) ? (io_wdata | 'h03) : io_wdata;
          end
        end
      end
    end
    #5;
    if (rst_n) begin
      chk("R5/R13 rdata A", rd_a, e_rd(0));
      chk("R5/R13 rdata B", rd_b, e_rd(1));
      chk("R7 port_base A", base_a, e_base(0));
      chk("R7 port_base B", base_b, e_base(1));
      chk("R8 spp_sel A", spp_a, (m_cr1[0] >> 3) & 1);
      chk("R8 spp_sel B", spp_b, (m_cr1[1] >> 3) & 1);
      chk("R9 ext_mode A", ext_a, m_cr4[0] % 4);
      chk("R9 ext_mode B", ext_b, m_cr4[1] % 4);
      chk("R10 epp_v17 A", epp_a, (m_cr4[0] >> 6) & 1);
      chk("R10 epp_v17 B", epp_b, (m_cr4[1] >> 6) & 1);
    end
  end

  task automatic wr(int a, int d);
    @(negedge clk); io_addr = a[15:0]; io_wdata = d[7:0]; io_wr = 1'b1;
    @(negedge clk); io_wr = 1'b0;
  endtask

  task automatic rd(int a, logic b, int exp, string tag);
    @(negedge clk); io_addr = a[15:0]; io_wr = 1'b0;
    #2 chk(tag, b ? rd_b : rd_a, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #2;
    chk("R1 base A", base_a, 'h378); chk("R1 spp A", spp_a, 1); chk("R1 ext A", ext_a, 0);
    chk("R1 epp A", epp_a, 0); chk("R1 spp B", spp_b, 0); chk("R1 ext B", ext_b, 3);
    rd('h3F1, 0, 'hFF, "R1 locked read A");
    // R5: locked data writes ignored
    wr('h3F1, 'h01); wr('h3F1, 'h00);
    rd('h3F1, 0, 'hFF, "R5 locked read");
    // R3: key, other write, key -> locked
    wr('h3F0, 'h55); wr('h100, 'h00); wr('h3F0, 'h55);
    rd('h3F1, 0, 'hFF, "R3 cancelled unlock");
    // R12: wrong address / wrong key
    wr('h370, 'h55); wr('h370, 'h55);
    rd('h371, 1, 'hFF, "R12 wrong key at B index");
    rd('h3F1, 0, 'hFF, "R12 A key at other index");
    wr('h3F0, 'h44); wr('h3F0, 'h44);
    rd('h3F1, 0, 'hFF, "R2 wrong key for A");
    // R2 unlock with idle gap
    wr('h3F0, 'h55); repeat (3) @(negedge clk); wr('h3F0, 'h55);
    wr('h3F0, 'h01);
    rd('h3F1, 0, 'h0A, "R5 CR1 untouched by locked writes");
    wr('h3F0, 'h0D);
    rd('h3F1, 0, 'h65, "R6 ID A");
    // R7 base mapping
    wr('h3F0, 'h01);
    for (int v = 0; v < 4; v++) begin
      wr('h3F1, 'h08 | v);
      rd('h3F1, 0, 'h08 | v, "R7 CR1 readback");
      chk("R7 base", base_a, (v == 0) ? 0 : (v == 1) ? 'h3BC : (v == 2) ? 'h378 : 'h278);
    end
    wr('h3F1, 'h02); #2 chk("R8 extended select", spp_a, 0);
    wr('h3F1, 'h0A); #2 chk("R8 SPP select", spp_a, 1);
    wr('h3F0, 'h04);
    for (int v = 0; v < 4; v++) begin
      wr('h3F1, v); #2 chk("R9 ext_mode", ext_a, v);
    end
    wr('h3F1, 'h40); #2 chk("R10 EPP 1.7", epp_a, 1);
    wr('h3F1, 'h00); #2 chk("R10 EPP 1.9", epp_a, 0);
    wr('h3F0, 'h07);
    rd('h3F1, 0, 'h00, "R13 unused index");
    rd('h3F0, 0, 'hFF, "R13 index port read");
    wr('h3F0, 'hAA);
    rd('h3F1, 0, 'hFF, "R4 relocked");
    chk("R4 base kept", base_a, 'h378);
    // R11 variant B at alternate index
    wr('h370, 'h44); wr('h370, 'h44);
    wr('h370, 'h0D);
    rd('h371, 1, 'h66, "R6 ID B");
    wr('h370, 'h01); wr('h371, 'h0B);
    rd('h371, 1, 'h03, "R11 CR1 mode bit fixed");
    chk("R11 spp B", spp_b, 0); chk("R7 base B", base_b, 'h278);
    wr('h370, 'h04); wr('h371, 'h40);
    rd('h371, 1, 'h43, "R11 CR4 mode fixed");
    chk("R11 ext B", ext_b, 3); chk("R10 epp B", epp_b, 1);
    rd('h3F1, 0, 'hFF, "R12 A unaffected");
    wr('h370, 'hAA);
    rd('h371, 1, 'hFF, "R4 B relocked");
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule